// File: doc/BRIEF.md
# Programmable Square-Wave Tap Selector

This block makes a square wave from a 32.768 kHz reference clock. A free-running binary counter, clocked by the reference, divides it down. A 4-bit rate code picks one of thirteen counter bits to drive the output pin. Because every counter bit toggles evenly, each selected rate has a 50% duty cycle. A pass-through control bypasses the divider and sends the reference clock itself to the pin. A master enable holds the pin low when it is cleared.

A supply-aware gate sits in front of the output. When the main supply is present, only the enable, pass-through and rate controls decide the output. When the main supply is gone, the pin carries the raw reference only if four conditions all hold: the enable is set, pass-through is set, backup operation is allowed, and the backup supply is present. In any other case the pin stays low. The selection is captured on each reference edge, so a control change reaches the pin at the next rising edge of the reference.

Top module: `sqw_tap_selector`

## Requirements
- R1: While `sq_en` is 0, `sq_out` stays low for any `raw_sel`, `rate_sel` and supply inputs.
- R2: With the main supply present, `sq_en`=1 and `raw_sel`=1, `sq_out` follows `clk_32k` (high while it is high, low while it is low), whatever `rate_sel` holds.
- R3: With the main supply present, `sq_en`=1 and `raw_sel`=0, rate codes 3 to 15 give half-periods of 2^(code-2) reference cycles. This runs from 8192 Hz for code 3 down to 2 Hz for code 15.
- R4: Rate code 0 with `raw_sel`=0 keeps `sq_out` low.
- R5: Rate code 1 gives 256 Hz (half-period 64 cycles) and rate code 2 gives 128 Hz (half-period 128 cycles).
- R6: With `main_pwr_ok`=0, `sq_out` follows `clk_32k` only when `sq_en`, `raw_sel`, `aux_bat_en` and `aux_pwr_ok` are all 1. Otherwise it is low, and this includes any divided rate.
- R7: Every divided rate has equal high and low times.
- R8: A change of the controls has no effect on `sq_out` before the next rising edge of `clk_32k`, and it is in effect just after that edge.
- R9: While `rst_n` is low, `sq_out` is low whatever the controls are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_32k | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sq_en | input | 1 | Master output enable |
| raw_sel | input | 1 | Pass the undivided reference to the pin |
| rate_sel | input | 4 | Rate code that selects the divider tap |
| aux_bat_en | input | 1 | Allows output on backup power |
| main_pwr_ok | input | 1 | Main supply present |
| aux_pwr_ok | input | 1 | Backup supply present |
| sq_out | output | 1 | Square-wave output |

## Verification
The hardest cases to reach are the slowest taps, because the lowest rate needs thousands of reference cycles before a single edge shows. The stimulus handles this by finding an output edge and then timing a whole high phase and a whole low phase for each code. It never depends on the counter's phase after reset. A second hard point is showing that a control change waits for the clock edge. For this the bench changes `raw_sel` in the middle of a high phase and samples the pin both before and after the next rising edge.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int CNT_W  = 14;
  localparam int RATE_W = 4;
  localparam int IDX_W  = $clog2(CNT_W);

  typedef enum logic [1:0] {
    SQ_OFF = 2'd0,
    SQ_RAW = 2'd1,
    SQ_TAP = 2'd2
  } sq_mode_e;

  // Counter bit k toggles at 32768 / 2^(k+1) Hz.
  function automatic logic [IDX_W-1:0] rate_to_tap(input logic [RATE_W-1:0] code);
    logic [IDX_W-1:0] tap;
    case (code)
      4'd0:    tap = '0;
      4'd1:    tap = IDX_W'(6);
      4'd2:    tap = IDX_W'(7);
      default: tap = IDX_W'(code - 4'd2);
    endcase
    return tap;
  endfunction
endpackage

// File: rtl/sqw_rst_sync.sv
module sqw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         past_ok_q;

  always_comb begin
    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      past_ok_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      past_ok_q <= 1'b1;
    end
  end

  assign cnt = cnt_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (cnt_q == W'($past(cnt_q) + W'(1))));  // R7
endmodule

// File: rtl/sqw_ctrl.sv
module sqw_ctrl
  import sqw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sq_en,
  input  logic                raw_sel,
  input  logic [RATE_W-1:0]   rate_sel,
  input  logic                aux_bat_en,
  input  logic                main_pwr_ok,
  input  logic                aux_pwr_ok,
  output sq_mode_e            mode,
  output logic [IDX_W-1:0]    tap_idx
);
  sq_mode_e         mode_q, mode_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             upd_en;

  always_comb begin
    idx_d = rate_to_tap(rate_sel);
    if (!sq_en) begin
      mode_d = SQ_OFF;
    end else if (!main_pwr_ok) begin
      mode_d = (raw_sel && aux_bat_en && aux_pwr_ok) ? SQ_RAW : SQ_OFF;
    end else if (raw_sel) begin
      mode_d = SQ_RAW;
    end else if (rate_sel == '0) begin
      mode_d = SQ_OFF;
    end else begin
      mode_d = SQ_TAP;
    end
    upd_en = (mode_d != mode_q) || (idx_d != idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SQ_OFF;
      idx_q  <= '0;
    end else if (upd_en) begin
      mode_q <= mode_d;
      idx_q  <= idx_d;
    end
  end

  assign mode    = mode_q;
  assign tap_idx = idx_q;

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_en |=> (mode_q == SQ_OFF));  // R1
  AST_RAW_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_en && raw_sel && main_pwr_ok) |=> (mode_q == SQ_RAW));  // R2
  AST_CODE_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_en && !raw_sel && main_pwr_ok && rate_sel == '0) |=> (mode_q == SQ_OFF));  // R4
  AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_pwr_ok && !(sq_en && raw_sel && aux_bat_en && aux_pwr_ok)) |=> (mode_q == SQ_OFF));  // R6
  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SQ_TAP) |-> (idx_q >= IDX_W'(1) && idx_q <= IDX_W'(13)));  // R3
endmodule

// File: rtl/sqw_tap_selector.sv
module sqw_tap_selector
  import sqw_pkg::*;
(
  input  logic              clk_32k,
  input  logic              rst_n,
  input  logic              sq_en,
  input  logic              raw_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              aux_bat_en,
  input  logic              main_pwr_ok,
  input  logic              aux_pwr_ok,
  output logic              sq_out
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;
  sq_mode_e         mode;
  logic [IDX_W-1:0] tap_idx;
  logic [CNT_W-1:0] tap_hit;
  logic             tap_out;

  sqw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk_32k),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sqw_divider #(.W(CNT_W)) u_divider (
    .clk   (clk_32k),
    .rst_n (rst_sync_n),
    .cnt   (cnt)
  );

  sqw_ctrl u_ctrl (
    .clk         (clk_32k),
    .rst_n       (rst_sync_n),
    .sq_en       (sq_en),
    .raw_sel     (raw_sel),
    .rate_sel    (rate_sel),
    .aux_bat_en  (aux_bat_en),
    .main_pwr_ok (main_pwr_ok),
    .aux_pwr_ok  (aux_pwr_ok),
    .mode        (mode),
    .tap_idx     (tap_idx)
  );

  for (genvar k = 0; k < CNT_W; k++) begin : g_tap
    assign tap_hit[k] = (tap_idx == IDX_W'(k)) & cnt[k];
  end

  assign tap_out = |tap_hit;

  always_comb begin
    case (mode)
      SQ_RAW:  sq_out = clk_32k;
      SQ_TAP:  sq_out = tap_out;
      default: sq_out = 1'b0;
    endcase
  end

  AST_LOW_IN_RESET: assert property (@(posedge clk_32k)
    !rst_n |-> (mode == SQ_OFF));  // R9
endmodule

// File: tb/sqw_tap_selector_bench.sv
module sqw_tap_selector_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_32k = 1'b0;
  logic       rst_n;
  logic       sq_en, raw_sel, aux_bat_en, main_pwr_ok, aux_pwr_ok;
  logic [3:0] rate_sel;
  logic       sq_out;

  int n_tests = 0;
  int n_fail  = 0;

  sqw_tap_selector u_sqw_tap_selector (
    .clk_32k     (clk_32k),
    .rst_n       (rst_n),
    .sq_en       (sq_en),
    .raw_sel     (raw_sel),
    .rate_sel    (rate_sel),
    .aux_bat_en  (aux_bat_en),
    .main_pwr_ok (main_pwr_ok),
    .aux_pwr_ok  (aux_pwr_ok),
    .sq_out      (sq_out)
  );

  always #(CLK_PERIOD/2) clk_32k = ~clk_32k;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic en, input logic raw, input logic [3:0] rate,
                          input logic bat, input logic main_ok, input logic aux_ok);
    @(negedge clk_32k);
    sq_en = en; raw_sel = raw; rate_sel = rate;
    aux_bat_en = bat; main_pwr_ok = main_ok; aux_pwr_ok = aux_ok;
    repeat (2) @(negedge clk_32k);
  endtask

  // Sample within the high phase and within the low phase of the reference.
  task automatic sample_hi(output logic v);
    @(posedge clk_32k); #2; v = sq_out;
  endtask
  task automatic sample_lo(output logic v);
    @(negedge clk_32k); #2; v = sq_out;
  endtask

  task automatic all_low(input string req, input int cycles);
    int highs = 0;
    logic v;
    for (int i = 0; i < cycles; i++) begin
      sample_hi(v); if (v) highs++;
      sample_lo(v); if (v) highs++;
    end
    check(req, highs, 0);
  endtask

  task automatic measure(output int hi, output int lo);
    logic v;
    int guard = 0;
    hi = 0; lo = 0;
    sample_lo(v);
    while (v && guard < 40000) begin sample_lo(v); guard++; end
    while (!v && guard < 40000) begin sample_lo(v); guard++; end
    hi = 1;
    sample_lo(v);
    while (v && hi < 40000) begin hi++; sample_lo(v); end
    lo = 1;
    sample_lo(v);
    while (!v && lo < 40000) begin lo++; sample_lo(v); end
  endtask

  task automatic t_reset;
    logic v;
    rst_n = 1'b0;
    sq_en = 1'b1; raw_sel = 1'b1; rate_sel = 4'd3;
    aux_bat_en = 1'b1; main_pwr_ok = 1'b1; aux_pwr_ok = 1'b1;
    repeat (3) @(negedge clk_32k);
    sample_hi(v); check("R9 low in reset (high phase)", v, 0);
    sample_lo(v); check("R9 low in reset (low phase)", v, 0);
    @(negedge clk_32k); rst_n = 1'b1;
    repeat (4) @(negedge clk_32k);
  endtask

  task automatic t_disabled;
    set_ctrl(1'b0, 1'b1, 4'd3, 1'b1, 1'b1, 1'b1);
    all_low("R1 disabled with pass-through", 40);
    set_ctrl(1'b0, 1'b0, 4'd3, 1'b1, 1'b1, 1'b1);
    all_low("R1 disabled with rate 3", 40);
  endtask

  task automatic t_code_zero;
    set_ctrl(1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0);
    all_low("R4 rate code 0", 300);
  endtask

  task automatic t_raw;
    logic v;
    set_ctrl(1'b1, 1'b1, 4'd5, 1'b0, 1'b1, 1'b0);
    sample_hi(v); check("R2 pass-through high phase", v, 1);
    sample_lo(v); check("R2 pass-through low phase", v, 0);
    set_ctrl(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0);
    sample_hi(v); check("R2 pass-through with code 0", v, 1);
  endtask

  task automatic t_rates;
    int hi, lo;
    for (int code = 3; code <= 15; code++) begin
      set_ctrl(1'b1, 1'b0, 4'(code), 1'b0, 1'b1, 1'b0);
      measure(hi, lo);
      check($sformatf("R3 half-period code %0d", code), hi, 1 << (code - 2));
      check($sformatf("R7 duty code %0d", code), lo, hi);
    end
  endtask

  task automatic t_low_codes;
    int hi, lo;
    set_ctrl(1'b1, 1'b0, 4'd1, 1'b0, 1'b1, 1'b0);
    measure(hi, lo);
    check("R5 code 1 half-period", hi, 64);
    check("R7 code 1 duty", lo, hi);
    set_ctrl(1'b1, 1'b0, 4'd2, 1'b0, 1'b1, 1'b0);
    measure(hi, lo);
    check("R5 code 2 half-period", hi, 128);
    check("R7 code 2 duty", lo, hi);
  endtask

  task automatic t_backup;
    logic v;
    set_ctrl(1'b1, 1'b1, 4'd3, 1'b1, 1'b0, 1'b1);
    sample_hi(v); check("R6 backup all conditions high phase", v, 1);
    sample_lo(v); check("R6 backup all conditions low phase", v, 0);
    set_ctrl(1'b0, 1'b1, 4'd3, 1'b1, 1'b0, 1'b1);
    all_low("R6 backup without enable", 8);
    set_ctrl(1'b1, 1'b0, 4'd3, 1'b1, 1'b0, 1'b1);
    all_low("R6 backup divided rate blocked", 8);
    set_ctrl(1'b1, 1'b1, 4'd3, 1'b0, 1'b0, 1'b1);
    all_low("R6 backup not allowed", 8);
    set_ctrl(1'b1, 1'b1, 4'd3, 1'b1, 1'b0, 1'b0);
    all_low("R6 backup supply absent", 8);
  endtask

  task automatic t_switch_timing;
    logic v;
    set_ctrl(1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0);
    @(posedge clk_32k); #1;
    raw_sel = 1'b1;
    #1; check("R8 no effect before edge", sq_out, 0);
    sample_hi(v); check("R8 effect after edge", v, 1);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_code_zero();
    t_raw();
    t_low_codes();
    t_backup();
    t_switch_timing();
    t_rates();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule